// File: doc/BRIEF.md
# DLL Relock Sequencer

This block runs on the memory-controller side and brings a DRAM device out of DLL-off operation and back to DLL-on operation. It uses a stay in self refresh as the only window in which the interface clock may be retuned. After a single start pulse it does the following:

- It issues a self-refresh entry.
- It asks the clock generator for a frequency change and waits for that request to be acknowledged.
- It lets the new clock settle, then leaves self refresh.
- It writes the mode registers that turn the DLL back on and reset it.
- It reprograms the latency registers.
- It reports completion once the final mode-register settling time has passed.

Each settling interval comes from its own programmable cycle count. All intervals share one down-counter, which is reloaded whenever a wait begins. The command bus carries a two-bit command code, a mode-register index and a data word. In every cycle that is not a command step, the bus carries the no-operation code with the index and data at zero.

Before the start pulse, the device is expected to sit in the DLL-off configuration. In that configuration only a read latency of 6 and a write latency of 6 are legal, and on-die termination is off. The block does not check these conditions; the system is responsible for meeting them before it asserts start.

Top module: `dll_relock_seq`

## Requirements
- R1: After reset, and after any reset asserted in the middle of a sequence, the block is idle. In that state the command code is no-operation, clk_chg_req_o and done_o are low, and no command appears until the next start.
- R2: A start pulse in the idle state produces a self-refresh entry command (code 1) in the next cycle. In the cycle after that, clk_chg_req_o goes high and stays high until clk_chg_ack_i is sampled high.
- R3: The cycle in which the acknowledge is sampled is followed by exactly max(t_cksrx_i,1) no-operation cycles, with the request low. The next cycle carries a self-refresh exit command (code 2).
- R4: After self-refresh exit, exactly max(t_xs_i,1) no-operation cycles pass. Then a mode-register write (code 3) goes to index 1, with data equal to mr1_cfg_i except that bit 0 is forced to 0, which turns the DLL on.
- R5: After exactly max(t_mrd_i,1) no-operation cycles, a mode-register write goes to index 0, with data equal to mr0_cfg_i except that bit 8 is forced to 1, which starts the DLL reset.
- R6: After another max(t_mrd_i,1) no-operation cycles, index 0 is written again with mr0_cfg_i and bit 8 forced to 0, carrying the new read latency and write recovery. After a further max(t_mrd_i,1) no-operation cycles, index 2 is written with mr2_cfg_i, carrying the new write latency.
- R7: Exactly max(t_mod_i,1) no-operation cycles after the index-2 write, done_o is high for one cycle. The block is then idle.
- R8: A start pulse, or start held high, while a sequence is running has no effect: the timing and content of every command are unchanged, and no second sequence follows.
- R9: The command codes are no-operation 0, self-refresh entry 1, self-refresh exit 2 and mode-register write 3. Every cycle that is not one of the steps above carries code 0. mr_addr_o and mr_data_o are zero whenever the code is not 3.
- R10: A wait count of zero behaves exactly like a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only while idle |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_o | output | 2 | Command code (0 no-op, 1 SR entry, 2 SR exit, 3 MR write) |
| mr_addr_o | output | MRA_W | Mode-register index for code 3 |
| mr_data_o | output | MR_DW | Mode-register data for code 3 |
| clk_chg_req_o | output | 1 | Frequency change request to clock generator |
| clk_chg_ack_i | input | 1 | Frequency change acknowledge |
| mr0_cfg_i | input | MR_DW | Target content of register 0 |
| mr1_cfg_i | input | MR_DW | Target content of register 1 |
| mr2_cfg_i | input | MR_DW | Target content of register 2 |
| t_cksrx_i | input | CNT_W | Clock settle cycles before SR exit |
| t_xs_i | input | CNT_W | Cycles from SR exit to first MR write |
| t_mrd_i | input | CNT_W | Cycles between MR writes |
| t_mod_i | input | CNT_W | Cycles from last MR write to done |

## Verification
The hardest situations to reach from the ports are a start request arriving in the middle of a run and a reset that cuts a run short. The first is reached by holding start high from the first command cycle until just before the expected done pulse. The bench then confirms that every command keeps its predicted cycle and that exactly six commands and one done pulse occur. For the second, reset is asserted while the clock-change request is pending, and the bench then watches the idle bus. The acknowledge delay and the wait counts, including zero, vary across the vector table, so that every interval is measured against its own count.

// File: rtl/dll_relock_pkg.sv
package dll_relock_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_SRE = 2'd1,
    CMD_SRX = 2'd2,
    CMD_MRS = 2'd3
  } relock_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SRE, ST_CLKREQ, ST_WCKSRX, ST_SRX, ST_WXS,
    ST_MR1W, ST_WMRD1, ST_MR0R, ST_WMRD2, ST_MR0L, ST_WMRD3,
    ST_MR2W, ST_WMOD, ST_FIN
  } relock_st_e;

  localparam int unsigned MR0_IDX     = 0;
  localparam int unsigned MR1_IDX     = 1;
  localparam int unsigned MR2_IDX     = 2;
  localparam int unsigned DLL_OFF_BIT = 0;
  localparam int unsigned DLL_RST_BIT = 8;

endpackage

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import dll_relock_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  input  logic             wait_over,
  input  logic [CNT_W-1:0] n_cksrx,
  input  logic [CNT_W-1:0] n_xs,
  input  logic [CNT_W-1:0] n_mrd,
  input  logic [CNT_W-1:0] n_mod,
  output relock_st_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  // counter reload value giving a wait of max(n,1) cycles
  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  relock_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_SRE;
      ST_SRE:    st_d = ST_CLKREQ;
      ST_CLKREQ: if (ack) begin
                   st_d = ST_WCKSRX; tmr_load = 1'b1; tmr_val = reload_of(n_cksrx);
                 end
      ST_WCKSRX: if (wait_over) st_d = ST_SRX;
      ST_SRX:    begin st_d = ST_WXS; tmr_load = 1'b1; tmr_val = reload_of(n_xs); end
      ST_WXS:    if (wait_over) st_d = ST_MR1W;
      ST_MR1W:   begin st_d = ST_WMRD1; tmr_load = 1'b1; tmr_val = reload_of(n_mrd); end
      ST_WMRD1:  if (wait_over) st_d = ST_MR0R;
      ST_MR0R:   begin st_d = ST_WMRD2; tmr_load = 1'b1; tmr_val = reload_of(n_mrd); end
      ST_WMRD2:  if (wait_over) st_d = ST_MR0L;
      ST_MR0L:   begin st_d = ST_WMRD3; tmr_load = 1'b1; tmr_val = reload_of(n_mrd); end
      ST_WMRD3:  if (wait_over) st_d = ST_MR2W;
      ST_MR2W:   begin st_d = ST_WMOD; tmr_load = 1'b1; tmr_val = reload_of(n_mod); end
      ST_WMOD:   if (wait_over) st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/relock_cmd_drv.sv
module relock_cmd_drv
  import dll_relock_pkg::*;
#(
  parameter int MRA_W = 3,
  parameter int MR_DW = 14
) (
  input  relock_st_e       state,
  input  logic [MR_DW-1:0] mr0_cfg,
  input  logic [MR_DW-1:0] mr1_cfg,
  input  logic [MR_DW-1:0] mr2_cfg,
  output logic [1:0]       cmd,
  output logic [MRA_W-1:0] addr,
  output logic [MR_DW-1:0] data,
  output logic             req,
  output logic             fin
);
  localparam logic [MR_DW-1:0] RST_MASK = MR_DW'(1) << DLL_RST_BIT;
  localparam logic [MR_DW-1:0] OFF_MASK = MR_DW'(1) << DLL_OFF_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    data = '0;
    unique case (state)
      ST_SRE:  cmd = CMD_SRE;
      ST_SRX:  cmd = CMD_SRX;
      ST_MR1W: begin cmd = CMD_MRS; addr = MRA_W'(MR1_IDX); data = mr1_cfg & ~OFF_MASK; end
      ST_MR0R: begin cmd = CMD_MRS; addr = MRA_W'(MR0_IDX); data = mr0_cfg | RST_MASK;  end
      ST_MR0L: begin cmd = CMD_MRS; addr = MRA_W'(MR0_IDX); data = mr0_cfg & ~RST_MASK; end
      ST_MR2W: begin cmd = CMD_MRS; addr = MRA_W'(MR2_IDX); data = mr2_cfg;             end
      default: ;
    endcase
  end

  assign req = (state == ST_CLKREQ);
  assign fin = (state == ST_FIN);
endmodule

// File: rtl/dll_relock_seq.sv
module dll_relock_seq
  import dll_relock_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int MRA_W = 3,
  parameter int MR_DW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             done_o,
  output logic [1:0]       cmd_o,
  output logic [MRA_W-1:0] mr_addr_o,
  output logic [MR_DW-1:0] mr_data_o,
  output logic             clk_chg_req_o,
  input  logic             clk_chg_ack_i,
  input  logic [MR_DW-1:0] mr0_cfg_i,
  input  logic [MR_DW-1:0] mr1_cfg_i,
  input  logic [MR_DW-1:0] mr2_cfg_i,
  input  logic [CNT_W-1:0] t_cksrx_i,
  input  logic [CNT_W-1:0] t_xs_i,
  input  logic [CNT_W-1:0] t_mrd_i,
  input  logic [CNT_W-1:0] t_mod_i
);
  relock_st_e       seq_state;
  logic             wait_done_w;
  logic             wait_load_w;
  logic [CNT_W-1:0] wait_val_w;
  logic             seq_idle_w;

  relock_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .ack(clk_chg_ack_i),
    .wait_over(wait_done_w), .n_cksrx(t_cksrx_i), .n_xs(t_xs_i),
    .n_mrd(t_mrd_i), .n_mod(t_mod_i), .state(seq_state),
    .tmr_load(wait_load_w), .tmr_val(wait_val_w)
  );

  relock_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(wait_load_w), .load_val(wait_val_w),
    .expired(wait_done_w)
  );

  relock_cmd_drv #(.MRA_W(MRA_W), .MR_DW(MR_DW)) u_drv (
    .state(seq_state), .mr0_cfg(mr0_cfg_i), .mr1_cfg(mr1_cfg_i),
    .mr2_cfg(mr2_cfg_i), .cmd(cmd_o), .addr(mr_addr_o), .data(mr_data_o),
    .req(clk_chg_req_o), .fin(done_o)
  );

  assign seq_idle_w = (seq_state == ST_IDLE);
endmodule

// File: rtl/dll_relock_chk.sv
module dll_relock_chk #(
  parameter int MRA_W = 3,
  parameter int MR_DW = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_o,
  input logic [1:0]       cmd_o,
  input logic [MRA_W-1:0] mr_addr_o,
  input logic [MR_DW-1:0] mr_data_o,
  input logic             clk_chg_req_o,
  input logic             clk_chg_ack_i,
  input logic             seq_idle,
  input logic             wait_done
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chg_req_o && !clk_chg_ack_i |=> clk_chg_req_o); // R2
  AST_SRE_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o == 2'd1 |=> clk_chg_req_o); // R2
  AST_REQ_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chg_req_o |-> cmd_o == 2'd0); // R3
  AST_SRX_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o == 2'd2 |-> $past(wait_done)); // R3
  AST_DLL_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o == 2'd3 && mr_addr_o == MRA_W'(1) |-> !mr_data_o[0]); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && seq_idle); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |=> cmd_o != 2'd1); // R8
  AST_NOP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o != 2'd3 |-> mr_addr_o == '0 && mr_data_o == '0); // R9
endmodule

bind dll_relock_seq dll_relock_chk #(.MRA_W(MRA_W), .MR_DW(MR_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .cmd_o(cmd_o),
  .mr_addr_o(mr_addr_o), .mr_data_o(mr_data_o), .clk_chg_req_o(clk_chg_req_o),
  .clk_chg_ack_i(clk_chg_ack_i), .seq_idle(seq_idle_w), .wait_done(wait_done_w)
);

// File: tb/dll_relock_seq_test.sv
`timescale 1ns/1ps
module dll_relock_seq_test;
  localparam int CNT_W = 10;
  localparam int MRA_W = 3;
  localparam int MR_DW = 14;
  localparam int NV = 6;
  // {cksrx, xs, mrd, mod, ack_delay}
  localparam int VEC [NV][5] = '{
    '{3, 4, 2, 5, 0}, '{1, 1, 1, 1, 2}, '{0, 0, 0, 0, 0},
    '{7, 2, 3, 1, 4}, '{2, 9, 4, 6, 1}, '{5, 3, 0, 2, 3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic clk_chg_ack_i = 1'b0;
  logic [MR_DW-1:0] mr0_cfg_i = '0, mr1_cfg_i = '0, mr2_cfg_i = '0;
  logic [CNT_W-1:0] t_cksrx_i = '0, t_xs_i = '0, t_mrd_i = '0, t_mod_i = '0;
  logic done_o, clk_chg_req_o;
  logic [1:0] cmd_o;
  logic [MRA_W-1:0] mr_addr_o;
  logic [MR_DW-1:0] mr_data_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dll_relock_seq #(.CNT_W(CNT_W), .MRA_W(MRA_W), .MR_DW(MR_DW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .cmd_o(cmd_o), .mr_addr_o(mr_addr_o), .mr_data_o(mr_data_o),
    .clk_chg_req_o(clk_chg_req_o), .clk_chg_ack_i(clk_chg_ack_i),
    .mr0_cfg_i(mr0_cfg_i), .mr1_cfg_i(mr1_cfg_i), .mr2_cfg_i(mr2_cfg_i),
    .t_cksrx_i(t_cksrx_i), .t_xs_i(t_xs_i), .t_mrd_i(t_mrd_i), .t_mod_i(t_mod_i)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int atl1(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic run_seq(input int cks, input int xs, input int mrd, input int md,
                         input int ackd, input int seed, input bit poke);
    int ev_cyc [8];
    int ev_cmd [8];
    int ev_adr [8];
    int ev_dat [8];
    int nev = 0, req_first = -1, req_cnt = 0, done_cyc = -1, done_cnt = 0;
    int bad_fields = 0;
    int e_srx, e_mr1, e_mr0r, e_mr0l, e_mr2, e_done;
    int m0, m1, m2;
    m0 = (seed * 1237 + 77) & 16'h3FFF;
    m1 = 16'h3FFF - seed;
    m2 = 16'h00A5 + seed * 3;
    e_srx  = 2 + ackd + atl1(cks) + 1;
    e_mr1  = e_srx + atl1(xs) + 1;
    e_mr0r = e_mr1 + atl1(mrd) + 1;
    e_mr0l = e_mr0r + atl1(mrd) + 1;
    e_mr2  = e_mr0l + atl1(mrd) + 1;
    e_done = e_mr2 + atl1(md) + 1;
    @(negedge clk);
    mr0_cfg_i = MR_DW'(m0); mr1_cfg_i = MR_DW'(m1); mr2_cfg_i = MR_DW'(m2);
    t_cksrx_i = CNT_W'(cks); t_xs_i = CNT_W'(xs);
    t_mrd_i = CNT_W'(mrd); t_mod_i = CNT_W'(md);
    start_i = 1'b1;
    for (int cyc = 1; cyc < e_done + 6; cyc++) begin
      @(negedge clk);
      if (cmd_o != 2'd0) begin
        if (nev < 8) begin
          ev_cyc[nev] = cyc; ev_cmd[nev] = int'(cmd_o);
          ev_adr[nev] = int'(mr_addr_o); ev_dat[nev] = int'(mr_data_o);
        end
        nev++;
      end
      if (cmd_o != 2'd3 && (mr_addr_o != '0 || mr_data_o != '0)) bad_fields++;
      if (clk_chg_req_o) begin
        if (req_first < 0) req_first = cyc;
        req_cnt++;
      end
      if (done_o) begin done_cyc = cyc; done_cnt++; end
      clk_chg_ack_i = (clk_chg_req_o && cyc >= req_first + ackd);
      start_i = poke && (cyc < e_done);
    end
    start_i = 1'b0;
    clk_chg_ack_i = 1'b0;
    chk("R9 command count", nev, 6);
    if (nev >= 6) begin
      chk("R2 SRE cycle", ev_cyc[0], 1);
      chk("R9 SRE code", ev_cmd[0], 1);
      chk("R3 SRX cycle", ev_cyc[1], e_srx);
      chk("R9 SRX code", ev_cmd[1], 2);
      chk("R4 MR1 cycle", ev_cyc[2], e_mr1);
      chk("R4 MR1 index", ev_adr[2], 1);
      chk("R4 MR1 data", ev_dat[2], m1 & 16'h3FFE);
      chk("R5 MR0 reset cycle", ev_cyc[3], e_mr0r);
      chk("R5 MR0 reset index", ev_adr[3], 0);
      chk("R5 MR0 reset data", ev_dat[3], m0 | 16'h0100);
      chk("R6 MR0 latency cycle", ev_cyc[4], e_mr0l);
      chk("R6 MR0 latency data", ev_dat[4], m0 & 16'h3EFF);
      chk("R6 MR2 cycle", ev_cyc[5], e_mr2);
      chk("R6 MR2 index", ev_adr[5], 2);
      chk("R6 MR2 data", ev_dat[5], m2);
      chk("R9 MRS code", ev_cmd[5], 3);
    end
    chk("R2 request first cycle", req_first, 2);
    chk("R2 request length", req_cnt, ackd + 1);
    chk("R7 done cycle", done_cyc, e_done);
    chk("R7 done count", done_cnt, 1);
    chk("R9 idle fields", bad_fields, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", int'(cmd_o), 0);
    chk("R1 reset req", int'(clk_chg_req_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle cmd after release", int'(cmd_o), 0);
    chk("R9 idle data", int'(mr_data_o), 0);

    for (int i = 0; i < NV; i++)
      run_seq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], i, 1'b0);

    // R10: zero counts match counts of one
    run_seq(0, 0, 0, 0, 1, 9, 1'b0);
    run_seq(1, 1, 1, 1, 1, 9, 1'b0);

    // R8: start held through the whole run
    run_seq(4, 3, 2, 3, 2, 11, 1'b1);
    run_seq(0, 5, 1, 0, 0, 12, 1'b1);

    // R1: reset in the middle of a sequence
    @(negedge clk);
    t_cksrx_i = 10'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R2 request pending", int'(clk_chg_req_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset req", int'(clk_chg_req_o), 0);
    chk("R1 mid reset cmd", int'(cmd_o), 0);
    rst_n = 1'b1;
    begin
      int busy = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (cmd_o != 2'd0 || clk_chg_req_o || done_o) busy++;
      end
      chk("R1 quiet after mid reset", busy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule